// File: doc/BRIEF.md
# Receive Frame Statistics Classifier

This block sits beside a receive MAC and turns its per-octet and end-of-frame status into increment pulses for four receive statistics counters: octets, frames lost to receive buffer overflow, valid broadcast frames and valid multicast frames. The counters themselves, and any host access to them, live elsewhere. The block only decides which counter advances and when.

Octet counting is deliberately blind to frame quality. Every octet the receiver takes in is counted, frame check octets included. The two frame counters advance only for frames judged valid. A frame is valid when its frame check is good and its length falls inside a window. The window has a fixed lower edge of 64 bytes. Its upper edge is picked by two mode inputs: an extended-size (jumbo) enable and a tagged-frame allowance. The mode inputs are read on the same cycle as the frame-end strobe, so a mode change during a frame affects only frames that end after it. Misses come only from the separate overflow-drop strobe.

Every output is a single-cycle pulse, registered once: it is high in the cycle that follows the input strobe that caused it.

Top module: `rx_stat_classifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after a clock edge at which `rst` was high, all four increment outputs are low.
- R2: `inc_octets` is high in exactly the cycles that follow a cycle with `octet_stb` high, whatever the length, frame check or destination of the frame in progress.
- R3: `inc_missed` is high in exactly the cycles that follow a cycle with `drop_stb` high.
- R4: With `jumbo_en`=0 and `vlan_en`=0, a frame is valid only if `fcs_ok`=1 and 64 <= `frame_len` <= 1518.
- R5: With `jumbo_en`=0 and `vlan_en`=1, a frame is valid only if `fcs_ok`=1 and 64 <= `frame_len` <= 1522.
- R6: With `jumbo_en`=1, whatever `vlan_en` is, a frame is valid only if `fcs_ok`=1 and 64 <= `frame_len` <= 65536.
- R7: A frame ending with `fcs_ok`=0 never produces `inc_bcast` or `inc_mcast`.
- R8: `dest_kind` is encoded 2'b00 unicast, 2'b01 multicast, 2'b10 broadcast, 2'b11 reserved. A valid frame ending (`frame_end` high) with broadcast gives one `inc_bcast` pulse in the next cycle. One with multicast gives one `inc_mcast` pulse in the next cycle. Unicast or reserved gives neither. The two outputs are never high together, and neither is high unless `frame_end` was high in the cycle before.
- R9: The mode inputs are used only in the cycle in which `frame_end` is high. Their values in earlier cycles of the same frame have no effect.
- R10: Frame ends never produce `inc_missed`, whether the frame is undersize, oversize or has a bad frame check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| octet_stb | input | 1 | One received octet, preamble excluded |
| frame_end | input | 1 | Frame finished; qualifies length, check and destination |
| frame_len | input | 17 | Finished frame length in bytes |
| fcs_ok | input | 1 | Frame check sequence was correct |
| dest_kind | input | 2 | Destination address class (see R8) |
| drop_stb | input | 1 | Frame discarded because the receive buffer overflowed |
| jumbo_en | input | 1 | Extended-size frames allowed |
| vlan_en | input | 1 | Tagged-frame maximum length allowed |
| inc_octets | output | 1 | Increment pulse, octet counter |
| inc_missed | output | 1 | Increment pulse, missed-frame counter |
| inc_bcast | output | 1 | Increment pulse, broadcast frame counter |
| inc_mcast | output | 1 | Increment pulse, multicast frame counter |

## Verification
The bound checker watches, on every cycle, the things that relate one input cycle to the next output cycle. It checks that octet and miss pulses follow their strobes one for one. It checks that frame pulses never appear without a frame end, never come from a bad frame check or an undersize length, and never appear together. The exact upper length edge for each mode pair, and the choice between broadcast, multicast and unicast, need the bench's vectors. So does reading the mode at the frame-end cycle rather than earlier in the frame. The vectors sit on both sides of each limit and toggle the mode bits partway through a frame.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

    localparam int LEN_W_DEF     = 17;
    localparam int MIN_LEN_DEF   = 64;
    localparam int STD_MAX_DEF   = 1518;
    localparam int VLAN_MAX_DEF  = 1522;
    localparam int JUMBO_MAX_DEF = 65536;

    typedef enum logic [1:0] {
        DEST_UNI   = 2'b00,
        DEST_MULTI = 2'b01,
        DEST_BCAST = 2'b10,
        DEST_RSVD  = 2'b11
    } dest_kind_e;

    typedef struct packed {
        logic bcast;
        logic mcast;
    } frame_hits_t;

    typedef struct packed {
        logic octet;
        logic missed;
        logic bcast;
        logic mcast;
    } stat_pulses_t;

    // Upper length edge picked by the mode pair; jumbo dominates.
    function automatic int len_ceiling(input logic jumbo, input logic vlan,
                                       input int std_max, input int vlan_max,
                                       input int jumbo_max);
        if (jumbo)
            return jumbo_max;
        else if (vlan)
            return vlan_max;
        else
            return std_max;
    endfunction

endpackage

// File: rtl/rx_len_window.sv
module rx_len_window #(
    parameter int LEN_W     = rx_stat_pkg::LEN_W_DEF,
    parameter int MIN_LEN   = rx_stat_pkg::MIN_LEN_DEF,
    parameter int STD_MAX   = rx_stat_pkg::STD_MAX_DEF,
    parameter int VLAN_MAX  = rx_stat_pkg::VLAN_MAX_DEF,
    parameter int JUMBO_MAX = rx_stat_pkg::JUMBO_MAX_DEF
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic             jumbo,
    input  logic             vlan,
    output logic             in_range
);
    import rx_stat_pkg::*;

    localparam logic [LEN_W-1:0] LO_EDGE = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] HI_STD  = LEN_W'(STD_MAX);
    localparam logic [LEN_W-1:0] HI_VLAN = LEN_W'(VLAN_MAX);
    localparam logic [LEN_W-1:0] HI_JMB  = LEN_W'(JUMBO_MAX);

    logic [LEN_W-1:0] hi_edge;

    always_comb begin
        hi_edge  = LEN_W'(len_ceiling(jumbo, vlan, int'(HI_STD),
                                      int'(HI_VLAN), int'(HI_JMB)));
        in_range = (frame_len >= LO_EDGE) && (frame_len <= hi_edge);
    end

endmodule

// File: rtl/rx_dest_decode.sv
module rx_dest_decode (
    input  logic                      frame_end,
    input  logic                      frame_good,
    input  rx_stat_pkg::dest_kind_e   dest,
    output rx_stat_pkg::frame_hits_t  hits
);
    import rx_stat_pkg::*;

    always_comb begin
        hits = '0;
        if (frame_end && frame_good) begin
            unique case (dest)
                DEST_BCAST: hits.bcast = 1'b1;
                DEST_MULTI: hits.mcast = 1'b1;
                default:    hits       = '0;
            endcase
        end
    end

endmodule

// File: rtl/rx_pulse_reg.sv
module rx_pulse_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else
                q[i] <= d[i];
        end
    end

endmodule

// File: rtl/rx_stat_classifier.sv
module rx_stat_classifier #(
    parameter int LEN_W     = rx_stat_pkg::LEN_W_DEF,
    parameter int MIN_LEN   = rx_stat_pkg::MIN_LEN_DEF,
    parameter int STD_MAX   = rx_stat_pkg::STD_MAX_DEF,
    parameter int VLAN_MAX  = rx_stat_pkg::VLAN_MAX_DEF,
    parameter int JUMBO_MAX = rx_stat_pkg::JUMBO_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             octet_stb,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             fcs_ok,
    input  logic [1:0]       dest_kind,
    input  logic             drop_stb,
    input  logic             jumbo_en,
    input  logic             vlan_en,
    output logic             inc_octets,
    output logic             inc_missed,
    output logic             inc_bcast,
    output logic             inc_mcast
);
    import rx_stat_pkg::*;

    localparam int PULSE_W = $bits(stat_pulses_t);

    logic         len_ok;
    logic         frame_good;
    frame_hits_t  hits;
    stat_pulses_t next_p;
    stat_pulses_t cur_p;

    rx_len_window #(
        .LEN_W    (LEN_W),
        .MIN_LEN  (MIN_LEN),
        .STD_MAX  (STD_MAX),
        .VLAN_MAX (VLAN_MAX),
        .JUMBO_MAX(JUMBO_MAX)
    ) u_len (
        .frame_len(frame_len),
        .jumbo    (jumbo_en),
        .vlan     (vlan_en),
        .in_range (len_ok)
    );

    assign frame_good = len_ok && fcs_ok;

    rx_dest_decode u_dest (
        .frame_end (frame_end),
        .frame_good(frame_good),
        .dest      (dest_kind_e'(dest_kind)),
        .hits      (hits)
    );

    always_comb begin
        next_p.octet  = octet_stb;
        next_p.missed = drop_stb;
        next_p.bcast  = hits.bcast;
        next_p.mcast  = hits.mcast;
    end

    rx_pulse_reg #(.N(PULSE_W)) u_out (
        .clk(clk),
        .rst(rst),
        .d  (next_p),
        .q  (cur_p)
    );

    assign inc_octets = cur_p.octet;
    assign inc_missed = cur_p.missed;
    assign inc_bcast  = cur_p.bcast;
    assign inc_mcast  = cur_p.mcast;

endmodule

// File: rtl/rx_stat_classifier_chk.sv
module rx_stat_classifier_chk #(
    parameter int LEN_W   = rx_stat_pkg::LEN_W_DEF,
    parameter int MIN_LEN = rx_stat_pkg::MIN_LEN_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             octet_stb,
    input logic             frame_end,
    input logic [LEN_W-1:0] frame_len,
    input logic             fcs_ok,
    input logic             drop_stb,
    input logic             inc_octets,
    input logic             inc_missed,
    input logic             inc_bcast,
    input logic             inc_mcast
);
    // R2
    octet_follow_chk: assert property (@(posedge clk) disable iff (rst)
        octet_stb |=> inc_octets);
    // R2
    octet_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !octet_stb |=> !inc_octets);
    // R3
    miss_follow_chk: assert property (@(posedge clk) disable iff (rst)
        drop_stb |=> inc_missed);
    // R10
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !drop_stb |=> !inc_missed);
    // R7
    bad_fcs_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !fcs_ok) |=> (!inc_bcast && !inc_mcast));
    // R4
    undersize_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && (frame_len < LEN_W'(MIN_LEN))) |=> (!inc_bcast && !inc_mcast));
    // R8
    no_end_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> (!inc_bcast && !inc_mcast));
    // R8
    class_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inc_bcast, inc_mcast}));

endmodule

bind rx_stat_classifier rx_stat_classifier_chk #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .octet_stb (octet_stb),
    .frame_end (frame_end),
    .frame_len (frame_len),
    .fcs_ok    (fcs_ok),
    .drop_stb  (drop_stb),
    .inc_octets(inc_octets),
    .inc_missed(inc_missed),
    .inc_bcast (inc_bcast),
    .inc_mcast (inc_mcast)
);

// File: tb/rx_stat_classifier_tb.sv
module rx_stat_classifier_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        octet_stb = 1'b0;
    logic        frame_end = 1'b0;
    logic [16:0] frame_len = '0;
    logic        fcs_ok = 1'b0;
    logic [1:0]  dest_kind = 2'b00;
    logic        drop_stb = 1'b0;
    logic        jumbo_en = 1'b0;
    logic        vlan_en = 1'b0;
    logic        inc_octets, inc_missed, inc_bcast, inc_mcast;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rx_stat_classifier u_dut (
        .clk(clk), .rst(rst), .octet_stb(octet_stb), .frame_end(frame_end),
        .frame_len(frame_len), .fcs_ok(fcs_ok), .dest_kind(dest_kind),
        .drop_stb(drop_stb), .jumbo_en(jumbo_en), .vlan_en(vlan_en),
        .inc_octets(inc_octets), .inc_missed(inc_missed),
        .inc_bcast(inc_bcast), .inc_mcast(inc_mcast)
    );

    // {jumbo, vlan, len[16:0], fcs, dest[1:0], exp_bcast, exp_mcast}
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 1'b0, 17'd64,    1'b1, 2'd2, 1'b1, 1'b0},  // R4 low edge
        {1'b0, 1'b0, 17'd63,    1'b1, 2'd2, 1'b0, 1'b0},  // R4 undersize
        {1'b0, 1'b0, 17'd1518,  1'b1, 2'd1, 1'b0, 1'b1},  // R4 high edge
        {1'b0, 1'b0, 17'd1519,  1'b1, 2'd1, 1'b0, 1'b0},  // R4 oversize
        {1'b0, 1'b1, 17'd1522,  1'b1, 2'd2, 1'b1, 1'b0},  // R5 high edge
        {1'b0, 1'b1, 17'd1523,  1'b1, 2'd2, 1'b0, 1'b0},  // R5 oversize
        {1'b1, 1'b0, 17'd65536, 1'b1, 2'd1, 1'b0, 1'b1},  // R6 high edge
        {1'b1, 1'b0, 17'd1523,  1'b1, 2'd2, 1'b1, 1'b0},  // R6
        {1'b1, 1'b1, 17'd9000,  1'b1, 2'd1, 1'b0, 1'b1},  // R6 vlan ignored
        {1'b0, 1'b0, 17'd500,   1'b0, 2'd2, 1'b0, 1'b0},  // R7
        {1'b0, 1'b0, 17'd500,   1'b1, 2'd0, 1'b0, 1'b0},  // R8 unicast
        {1'b0, 1'b0, 17'd500,   1'b1, 2'd3, 1'b0, 1'b0},  // R8 reserved
        {1'b1, 1'b0, 17'd63,    1'b1, 2'd1, 1'b0, 1'b0},  // R6 undersize
        {1'b0, 1'b0, 17'd1522,  1'b1, 2'd2, 1'b0, 1'b0}   // R4 tag size off
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic end_frame(input logic j, input logic v, input logic [16:0] len,
                             input logic ok, input logic [1:0] d);
        @(negedge clk);
        jumbo_en = j; vlan_en = v; frame_len = len; fcs_ok = ok; dest_kind = d;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: strobes during reset must not leak out
        @(negedge clk);
        octet_stb = 1'b1; drop_stb = 1'b1;
        frame_end = 1'b1; frame_len = 17'd100; fcs_ok = 1'b1; dest_kind = 2'd2;
        @(negedge clk);
        chk("R1 octets", inc_octets, 1'b0);
        chk("R1 missed", inc_missed, 1'b0);
        chk("R1 bcast",  inc_bcast,  1'b0);
        chk("R1 mcast",  inc_mcast,  1'b0);
        octet_stb = 1'b0; drop_stb = 1'b0; frame_end = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", inc_octets | inc_missed | inc_bcast | inc_mcast, 1'b0);

        // Vector table: frame validity and classification
        for (int i = 0; i < NV; i++) begin
            end_frame(VEC[i][23], VEC[i][22], VEC[i][21:5], VEC[i][4], VEC[i][3:2]);
            chk($sformatf("R4-6/R8 vec%0d bcast", i), inc_bcast, VEC[i][1]);
            chk($sformatf("R4-6/R8 vec%0d mcast", i), inc_mcast, VEC[i][0]);
            chk($sformatf("R10 vec%0d missed", i), inc_missed, 1'b0);
        end

        // R2: octets of an errored, oversize frame still count
        @(negedge clk);
        octet_stb = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 octet pulse", inc_octets, 1'b1);
        end
        octet_stb = 1'b0;
        frame_end = 1'b1; frame_len = 17'd4000; fcs_ok = 1'b0; dest_kind = 2'd2;
        jumbo_en = 1'b0; vlan_en = 1'b0;
        @(negedge clk);
        frame_end = 1'b0;
        chk("R2 octet after last", inc_octets, 1'b0);
        chk("R7 errored frame bcast", inc_bcast, 1'b0);
        chk("R10 errored frame missed", inc_missed, 1'b0);

        // R3: drop strobe gives one miss pulse
        @(negedge clk);
        drop_stb = 1'b1;
        @(negedge clk);
        drop_stb = 1'b0;
        chk("R3 miss pulse", inc_missed, 1'b1);
        @(negedge clk);
        chk("R3 single pulse", inc_missed, 1'b0);

        // R9: jumbo set during frame, cleared at its end -> 2000 invalid
        @(negedge clk);
        jumbo_en = 1'b1; octet_stb = 1'b1;
        @(negedge clk);
        octet_stb = 1'b0;
        end_frame(1'b0, 1'b0, 17'd2000, 1'b1, 2'd1);
        chk("R9 mode at end (cleared)", inc_mcast, 1'b0);
        // R9: jumbo clear during frame, set at its end -> valid
        @(negedge clk);
        jumbo_en = 1'b0;
        @(negedge clk);
        end_frame(1'b1, 1'b0, 17'd2000, 1'b1, 2'd1);
        chk("R9 mode at end (set)", inc_mcast, 1'b1);

        // All strobes together
        @(negedge clk);
        octet_stb = 1'b1; drop_stb = 1'b1; frame_end = 1'b1;
        jumbo_en = 1'b0; vlan_en = 1'b0; frame_len = 17'd64; fcs_ok = 1'b1; dest_kind = 2'd2;
        @(negedge clk);
        octet_stb = 1'b0; drop_stb = 1'b0; frame_end = 1'b0;
        chk("R2 concurrent octet", inc_octets, 1'b1);
        chk("R3 concurrent miss",  inc_missed, 1'b1);
        chk("R8 concurrent bcast", inc_bcast,  1'b1);
        chk("R8 concurrent mcast", inc_mcast,  1'b0);

        // R1: reset in mid-run clears pulses
        octet_stb = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-run", inc_octets, 1'b0);
        rst = 1'b0; octet_stb = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule